// File: doc/BRIEF.md
# Static Memory Wait-State Sequencer

This block is the access timing engine of an external static memory controller. It takes one access request at a time. Each request names a target, which is either internal or one of several external chip selects, and a direction, read or write. For an external target the block drives an active-low chip select, a read strobe and a write strobe. The per-device configuration sets how long these strobes stay active. The active-low wait input from the device can stretch the access.

Between accesses the block adds the idle cycles that external devices need. A device that was read may still be driving the data bus, so a float countdown holds off any conflicting access until it expires. While that countdown runs, the block raises an inhibit output that keeps other masters off the external bus. The countdown keeps running while internal accesses are served. When two external accesses in a row go to different devices, the block adds one chip-select change cycle, but only if no float cycle was already inserted.

One chip select can run in display-controller mode. In that mode its select is narrowed by half a clock at each end, and read data is captured as the select is released. A done pulse marks the end of each access, and the block keeps the chip select and direction of the last external access.

Top module: `sram_wait_seq`

## Requirements
- R1: After reset, every `cs_n` bit, `rd_n` and `wr_n` are high; `done`, `rd_latch` and `bus_inhibit` are low; `req_ready` is high.
- R2: An external access lasts N+1 clock cycles with the strobes active, where N is the device's 3-bit field in `cfg_nws` (device k at bits 3k+2:3k) when its `cfg_wait_en` bit is set. When that bit is clear, N is taken as 0 whatever the field holds.
- R3: `rd_n` is low for every cycle of a read access. For a write, `wr_n` is low for half a clock when N=0, and for N full cycles from the start of the access when N≥1.
- R4: Suppose an external read ends with `done` in cycle E0 and the device's float value is T (field in `cfg_tdf`, same layout as `cfg_nws`). Then `bus_inhibit` is high for exactly T cycles starting at E0. A later external write, or an external read to a different device, cannot start its access phase before cycle E0+T.
- R5: The float countdown keeps decrementing while internal accesses are served.
- R6: Internal accesses never wait for float time. An external read to the same device that owns the pending float time starts without float cycles.
- R7: When `ext_wait_n` is low at a rising edge during an access phase, the access is extended by one cycle and `cs_n`, `rd_n`, `wr_n` and `rd_latch` keep their values.
- R8: Suppose two consecutive external accesses go to different devices and no float cycle was inserted before the second. Then exactly one idle cycle is inserted. If float cycles were inserted, no change cycle is added.
- R9: With `lcd_mode` high, chip select 3 goes low half a clock after its access phase begins and returns high half a clock before it ends. This mode is meant for N≥1.
- R10: `rd_latch` is high through the final access cycle of a normal read. For a display-mode read it is high only in the second half of that cycle, after the select is released.
- R11: `done` is a one-cycle pulse at the end of each access. `req_ready` is high only when the sequencer is idle. `last_cs` and `last_write` hold the target of the most recent external access and are not changed by internal accesses.
- R12: An internal access completes with `done` one cycle after acceptance and drives no chip select or strobe. At most one `cs_n` bit is ever low, and `rd_n` and `wr_n` are never both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge is the main edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ext | input | 1 | 1 = external device, 0 = internal target |
| req_cs | input | 2 | External device index |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ready | output | 1 | Sequencer idle; request accepted at the next edge |
| done | output | 1 | One-cycle pulse at access completion |
| cfg_wait_en | input | 4 | Per-device wait enable |
| cfg_nws | input | 12 | Per-device wait count, 3 bits each |
| cfg_tdf | input | 12 | Per-device float time 0..7, 3 bits each |
| lcd_mode | input | 1 | Display-controller timing on chip select 3 |
| ext_wait_n | input | 1 | Active-low wait from the device |
| cs_n | output | 4 | Active-low chip selects |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| rd_latch | output | 1 | Read data capture window |
| bus_inhibit | output | 1 | Float time pending; other masters held off |
| last_cs | output | 2 | Device of the last external access |
| last_write | output | 1 | Direction of the last external access |

## Verification
The embedded properties check several rules on every cycle. At most one select is low, and the two strobes are never low together. No access phase starts while another device's float time is still pending. Outputs freeze while the wait input holds an access, `done` never lasts two cycles, and the float counter never skips a step. The bench scenarios cover what depends on history and half-clock timing: strobe widths counted in half cycles, the number of float and change cycles that follow a particular sequence of devices, float time that runs out across internal accesses, and the narrowed select in display mode.

// File: rtl/sws_pkg.sv
package sws_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GAP  = 2'd1,
        ST_ACC  = 2'd2,
        ST_INT  = 2'd3
    } seq_st_e;

endpackage

// File: rtl/sws_float.sv
module sws_float #(
    parameter int NUM_CS = 4,
    parameter int TDF_W  = 3,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TDF_W-1:0] load_val,
    input  logic [CS_W-1:0]  load_cs,
    output logic [TDF_W-1:0] cnt,
    output logic [CS_W-1:0]  owner,
    output logic             busy_next,
    output logic             inhibit
);

    typedef struct packed {
        logic [TDF_W-1:0] cnt;
        logic [CS_W-1:0]  owner;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d = flt_q;
        if (load) begin
            flt_d.cnt   = load_val;
            flt_d.owner = load_cs;
        end else if (flt_q.cnt != '0) begin
            flt_d.cnt = flt_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q <= '0;
        end else begin
            flt_q <= flt_d;
        end
    end

    assign cnt       = flt_q.cnt;
    assign owner     = flt_q.owner;
    assign busy_next = (flt_q.cnt > TDF_W'(1));
    assign inhibit   = (flt_q.cnt != '0);

    AST_FLT_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_q.cnt != '0 && !load) |=> (flt_q.cnt == $past(flt_q.cnt) - 1'b1)); // R5

    AST_FLT_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_q.cnt == '0 && !load) |=> (flt_q.cnt == '0)); // R4

endmodule

// File: rtl/sws_strobe.sv
module sws_strobe #(
    parameter int NUM_CS = 4,
    parameter int LCD_CS = 3,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic [CS_W-1:0]   cs,
    input  logic              wr,
    input  logic              nws0,
    input  logic              lcd,
    input  logic              cnt_nz,
    output logic [NUM_CS-1:0] cs_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              rd_latch
);

    typedef struct packed {
        logic wr_cut;
        logic lcd_on;
    } half_t;

    half_t half_d, half_q;

    always_comb begin
        half_d        = half_q;
        half_d.wr_cut = acc && wr && nws0;
        half_d.lcd_on = acc && lcd && cnt_nz;
    end

    // falling-edge stage gives the half-clock edges
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= '0;
        end else begin
            half_q <= half_d;
        end
    end

    for (genvar k = 0; k < NUM_CS; k++) begin : g_sel
        localparam logic [CS_W-1:0] KID = CS_W'(k);
        if (k == LCD_CS) begin : g_lcd
            assign cs_n[k] = !((acc && cs == KID && !lcd) || half_q.lcd_on);
        end else begin : g_std
            assign cs_n[k] = !(acc && cs == KID);
        end
    end

    assign rd_n     = !(acc && !wr);
    assign wr_n     = !(acc && wr && (cnt_nz || nws0) && !half_q.wr_cut);
    assign rd_latch = acc && !wr && !cnt_nz && (!lcd || !half_q.lcd_on);

    AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1); // R12

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n)); // R12

endmodule

// File: rtl/sram_wait_seq.sv
module sram_wait_seq
    import sws_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int NWS_W  = 3,
    parameter int TDF_W  = 3,
    parameter int LCD_CS = 3,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_ext,
    input  logic [CS_W-1:0]         req_cs,
    input  logic                    req_write,
    output logic                    req_ready,
    output logic                    done,
    input  logic [NUM_CS-1:0]       cfg_wait_en,
    input  logic [NUM_CS*NWS_W-1:0] cfg_nws,
    input  logic [NUM_CS*TDF_W-1:0] cfg_tdf,
    input  logic                    lcd_mode,
    input  logic                    ext_wait_n,
    output logic [NUM_CS-1:0]       cs_n,
    output logic                    rd_n,
    output logic                    wr_n,
    output logic                    rd_latch,
    output logic                    bus_inhibit,
    output logic [CS_W-1:0]         last_cs,
    output logic                    last_write
);

    typedef struct packed {
        seq_st_e          st;
        logic [CS_W-1:0]  cs;
        logic             wr;
        logic             nws0;
        logic             lcd;
        logic [NWS_W-1:0] cnt;
        logic [TDF_W-1:0] tdf;
        logic             csw;
        logic [CS_W-1:0]  last_cs;
        logic             last_wr;
        logic             have_prev;
        logic             done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic             flt_load;
    logic [TDF_W-1:0] flt_cnt;
    logic [CS_W-1:0]  flt_owner;
    logic             flt_busy_next;
    logic             flt_inhibit;
    logic [NWS_W-1:0] sel_nws;
    logic [TDF_W-1:0] sel_tdf;
    logic             sel_en;

    always_comb begin
        sel_en  = cfg_wait_en[req_cs];
        sel_nws = cfg_nws[int'(req_cs)*NWS_W +: NWS_W];
        sel_tdf = cfg_tdf[int'(req_cs)*TDF_W +: TDF_W];
    end

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        flt_load   = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.cs   = req_cs;
                    seq_d.wr   = req_write;
                    seq_d.cnt  = sel_en ? sel_nws : '0;
                    seq_d.nws0 = !sel_en || (sel_nws == '0);
                    seq_d.tdf  = sel_tdf;
                    seq_d.lcd  = lcd_mode && (int'(req_cs) == LCD_CS);
                    seq_d.csw  = 1'b0;
                    if (!req_ext) begin
                        seq_d.st = ST_INT;
                    end else if (flt_busy_next &&
                                 (req_cs != flt_owner || req_write)) begin
                        seq_d.st = ST_GAP;
                    end else if (seq_q.have_prev && seq_q.last_cs != req_cs) begin
                        seq_d.st  = ST_GAP;
                        seq_d.csw = 1'b1;
                    end else begin
                        seq_d.st = ST_ACC;
                    end
                end
            end
            ST_GAP: begin
                if (seq_q.csw || !flt_busy_next) begin
                    seq_d.st  = ST_ACC;
                    seq_d.csw = 1'b0;
                end
            end
            ST_ACC: begin
                if (ext_wait_n) begin
                    if (seq_q.cnt == '0) begin
                        seq_d.st        = ST_IDLE;
                        seq_d.done      = 1'b1;
                        seq_d.last_cs   = seq_q.cs;
                        seq_d.last_wr   = seq_q.wr;
                        seq_d.have_prev = 1'b1;
                        flt_load        = !seq_q.wr;
                    end else begin
                        seq_d.cnt = seq_q.cnt - 1'b1;
                    end
                end
            end
            ST_INT: begin
                seq_d.st   = ST_IDLE;
                seq_d.done = 1'b1;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    sws_float #(
        .NUM_CS (NUM_CS),
        .TDF_W  (TDF_W)
    ) u_float (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (flt_load),
        .load_val  (seq_q.tdf),
        .load_cs   (seq_q.cs),
        .cnt       (flt_cnt),
        .owner     (flt_owner),
        .busy_next (flt_busy_next),
        .inhibit   (flt_inhibit)
    );

    sws_strobe #(
        .NUM_CS (NUM_CS),
        .LCD_CS (LCD_CS)
    ) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (seq_q.st == ST_ACC),
        .cs       (seq_q.cs),
        .wr       (seq_q.wr),
        .nws0     (seq_q.nws0),
        .lcd      (seq_q.lcd),
        .cnt_nz   (seq_q.cnt != '0),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .rd_latch (rd_latch)
    );

    assign req_ready   = (seq_q.st == ST_IDLE);
    assign done        = seq_q.done;
    assign bus_inhibit = flt_inhibit;
    assign last_cs     = seq_q.last_cs;
    assign last_write  = seq_q.last_wr;

    AST_FLOAT_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_q.st == ST_ACC) |->
            (flt_cnt == '0 || (seq_q.cs == flt_owner && !seq_q.wr))); // R4

    AST_XWAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_ACC && !ext_wait_n) |=>
            ($stable(cs_n) && $stable(rd_n) && $stable(wr_n) && $stable(rd_latch))); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_INT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_INT) |-> (&cs_n && rd_n && wr_n)); // R12

endmodule

// File: tb/sram_wait_seq_bench.sv
`timescale 1ns/1ps
module sram_wait_seq_bench;

    localparam int PERIOD = 20;
    localparam int NVEC   = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ext = 1'b0;
    logic [1:0]  req_cs = '0;
    logic        req_write = 1'b0;
    logic        req_ready;
    logic        done;
    logic [3:0]  cfg_wait_en = 4'b1110;
    logic [11:0] cfg_nws = {3'd2, 3'd1, 3'd2, 3'd5};
    logic [11:0] cfg_tdf = {3'd0, 3'd5, 3'd0, 3'd2};
    logic        lcd_mode = 1'b1;
    logic        ext_wait_n = 1'b1;
    logic [3:0]  cs_n;
    logic        rd_n;
    logic        wr_n;
    logic        rd_latch;
    logic        bus_inhibit;
    logic [1:0]  last_cs;
    logic        last_write;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    sram_wait_seq u_sram_wait_seq (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ext (req_ext), .req_cs (req_cs),
        .req_write (req_write), .req_ready (req_ready), .done (done),
        .cfg_wait_en (cfg_wait_en), .cfg_nws (cfg_nws), .cfg_tdf (cfg_tdf),
        .lcd_mode (lcd_mode), .ext_wait_n (ext_wait_n),
        .cs_n (cs_n), .rd_n (rd_n), .wr_n (wr_n), .rd_latch (rd_latch),
        .bus_inhibit (bus_inhibit), .last_cs (last_cs), .last_write (last_write)
    );

    typedef struct packed {
        logic       ext;
        logic [1:0] cs;
        logic       wr;
        logic [2:0] xw;
        logic [7:0] lat;
        logic [7:0] rdh;
        logic [7:0] wrh;
        logic [7:0] csh;
        logic [7:0] lth;
    } vec_t;

    // device setup: d0 wait off (field 5 ignored) float 2; d1 N=2 float 0;
    // d2 N=1 float 5; d3 N=2 float 0, display mode
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 2'd0, 1'b0, 3'd0, 8'd1, 8'd2, 8'd0, 8'd2, 8'd2}, // R2 enable off
        '{1'b1, 2'd0, 1'b0, 3'd2, 8'd3, 8'd6, 8'd0, 8'd6, 8'd6}, // R6 R7 same dev read
        '{1'b1, 2'd0, 1'b1, 3'd0, 8'd2, 8'd0, 8'd1, 8'd2, 8'd0}, // R4 R3 half strobe
        '{1'b1, 2'd1, 1'b0, 3'd0, 8'd4, 8'd6, 8'd0, 8'd6, 8'd2}, // R8 R2
        '{1'b1, 2'd2, 1'b1, 3'd0, 8'd3, 8'd0, 8'd2, 8'd4, 8'd0}, // R8 R3
        '{1'b1, 2'd2, 1'b0, 3'd0, 8'd2, 8'd4, 8'd0, 8'd4, 8'd2}, // R2
        '{1'b1, 2'd0, 1'b0, 3'd0, 8'd5, 8'd2, 8'd0, 8'd2, 8'd2}, // R4 R8 no change cycle
        '{1'b0, 2'd0, 1'b0, 3'd0, 8'd1, 8'd0, 8'd0, 8'd0, 8'd0}, // R6 R12 internal
        '{1'b1, 2'd2, 1'b0, 3'd0, 8'd3, 8'd4, 8'd0, 8'd4, 8'd2}, // R8
        '{1'b0, 2'd0, 1'b0, 3'd0, 8'd1, 8'd0, 8'd0, 8'd0, 8'd0}, // R12
        '{1'b1, 2'd1, 1'b1, 3'd0, 8'd5, 8'd0, 8'd4, 8'd6, 8'd0}, // R5 float ran on
        '{1'b1, 2'd3, 1'b0, 3'd0, 8'd4, 8'd6, 8'd0, 8'd4, 8'd1}, // R9 R10 display read
        '{1'b1, 2'd3, 1'b1, 3'd1, 8'd4, 8'd0, 8'd6, 8'd6, 8'd0}  // R9 R7 display write
    };

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // called in the first half of a cycle; returns in the first half of the done cycle
    task automatic run_access(input logic ext, input logic [1:0] cs, input logic wr,
                              input int xw, output int lat, output int rdh,
                              output int wrh, output int csh, output int lth);
        int xl;
        bit fin;
        lat = 0; rdh = 0; wrh = 0; csh = 0; lth = 0;
        req_ext = ext; req_cs = cs; req_write = wr; req_valid = 1'b1;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        xl = xw;
        if (xl > 0) ext_wait_n = 1'b0;
        fin = 1'b0;
        while (!fin) begin
            #4;
            if (done || lat > 64) begin
                fin = 1'b1;
            end else begin
                if (!rd_n) rdh++;
                if (!wr_n) wrh++;
                if (!cs_n[cs]) csh++;
                if (rd_latch) lth++;
                #10;
                if (!rd_n) rdh++;
                if (!wr_n) wrh++;
                if (!cs_n[cs]) csh++;
                if (rd_latch) lth++;
                @(posedge clk);
                lat++;
                #1;
                if (xl > 0) begin
                    xl--;
                    if (xl == 0) ext_wait_n = 1'b1;
                end
            end
        end
    endtask

    initial begin
        int lat, rdh, wrh, csh, lth, cnt;
        logic [1:0] exp_last_cs;
        logic       exp_last_wr;
        exp_last_cs = '0;
        exp_last_wr = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #4;
        // R1 reset state
        chk("R1 cs_n", int'(cs_n), 15);
        chk("R1 rd_n/wr_n", int'({rd_n, wr_n}), 3);
        chk("R1 done/latch/inhibit", int'({done, rd_latch, bus_inhibit}), 0);
        chk("R1 ready", int'(req_ready), 1);

        for (int i = 0; i < NVEC; i++) begin
            chk("R11 ready when idle", int'(req_ready), 1);
            run_access(VEC[i].ext, VEC[i].cs, VEC[i].wr, int'(VEC[i].xw),
                       lat, rdh, wrh, csh, lth);
            chk("R2/R4/R5/R6/R7/R8/R12 cycles to done", lat, int'(VEC[i].lat));
            chk("R3 read strobe half cycles", rdh, int'(VEC[i].rdh));
            chk("R3 write strobe half cycles", wrh, int'(VEC[i].wrh));
            chk("R9 chip select half cycles", csh, int'(VEC[i].csh));
            chk("R10 capture half cycles", lth, int'(VEC[i].lth));
            if (VEC[i].ext) begin
                exp_last_cs = VEC[i].cs;
                exp_last_wr = VEC[i].wr;
            end
            chk("R11 last_cs", int'(last_cs), int'(exp_last_cs));
            chk("R11 last_write", int'(last_write), int'(exp_last_wr));
        end

        // R4 inhibit length after a device 2 read (float 5); change cycle first (R8)
        run_access(1'b1, 2'd2, 1'b0, 0, lat, rdh, wrh, csh, lth);
        chk("R8 cycles to done", lat, 3);
        cnt = 0;
        while (bus_inhibit && cnt < 20) begin
            cnt++;
            @(posedge clk);
            #5;
            if (cnt == 1) chk("R11 done single cycle", int'(done), 0);
        end
        chk("R4 inhibit cycles", cnt, 5);

        // R11 ready drops once a request is taken
        req_ext = 1'b1; req_cs = 2'd1; req_write = 1'b0; req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
        #4;
        chk("R11 ready while busy", int'(req_ready), 0);
        cnt = 0;
        while (!done && cnt < 40) begin
            cnt++;
            @(posedge clk);
            #5;
        end
        chk("R8 R2 cycles to done", cnt, 4);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(PERIOD * 20000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R11: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule